// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block lets a local processor and a remote processor notify each other through two independent banks of sixteen doorbell flags. It carries no message payload. The sender raises a flag, and the data travels through memory that lives outside the block. The local processor reaches the block through an APB-style register port. The remote side reaches it through two sideband vectors: one raises inbound doorbells and one acknowledges outbound doorbells.

The inbound direction (direction 0) receives flags from the remote side. Software on the local side can read these flags, mask them and clear them. The outbound direction (direction 1) is rung by software writing a generate register, and the remote side acknowledges it. Each direction drives one level interrupt. That interrupt is high while any flag in its direction is set and not masked. Flag N always belongs to channel N.

Register offsets (byte addresses, 32-bit words, flags in bits 15:0):

| Offset | Name | Access |
|---|---|---|
| 0x00 | control | reads zero, writes ignored |
| 0x24 | clear-0 | write-only, reads zero |
| 0x28 | mask-0 | read/write |
| 0x2C | status-0 | read-only |
| 0x30 | masked-status-0 | read-only |
| 0x40 | generate-1 | write-only, reads zero |
| 0x48 | mask-1 | read/write |
| 0x4C | status-1 | read-only |
| 0x50 | masked-status-1 | read-only |

Top module: `dbell_mailbox`

## Requirements
- R1: While reset is high and after it is released, every status bit and every mask bit is 0, and both interrupt outputs are low.
- R2: A write to generate-1 (0x40) sets status-1 bit N for every written bit N (N < 16) that is 1. Bits written as 0 leave their flags unchanged.
- R3: A write to clear-0 (0x24) clears status-0 bit N for every written 1 in bits 15:0. A 1 on `rmt_ack_i[N]` clears status-1 bit N. Zeros have no effect.
- R4: A 1 on `rmt_raise_i[N]` sets status-0 bit N on the next clock edge.
- R5: The mask registers (0x28, 0x48) store bits 15:0 of the written word and read them back. Masked-status (0x30, 0x50) reads as status AND NOT mask.
- R6: `irq_local_o` is the OR of masked-status-0, and `irq_remote_o` is the OR of masked-status-1. A mask of 0xFFFF holds the interrupt low while the status bits still latch and remain readable.
- R7: When the same flag is set and cleared on one clock edge, the flag ends up set.
- R8: Bits 31:16 of every register read as 0. Written ones in bits 31:16 (channel numbers 16 and above) change no flag and no mask bit.
- R9: Reads of 0x00, of the write-only registers and of any unmapped offset return 0. Writes to 0x00, to the status and masked-status offsets and to unmapped offsets change no state.
- R10: A write takes effect on the clock edge that ends its access phase (`psel_i`, `penable_i` and `pwrite_i` all high). Read data is valid in the same cycle as the address, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel_i | input | 1 | Register port select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while selected |
| rmt_raise_i | input | 16 | Remote side raises inbound flags (one bit per channel) |
| rmt_ack_i | input | 16 | Remote side clears outbound flags (one bit per channel) |
| irq_local_o | output | 1 | Inbound interrupt level |
| irq_remote_o | output | 1 | Outbound interrupt level |

## Verification
The properties assume that the register port holds its address and write data steady across the access-phase edge. They also assume that the remote vectors are sampled only on clock edges. The quiet-hold property further assumes that the remote vectors are zero whenever the remote side has nothing to signal. The bench drives every input on the falling edge, so values are stable at the sampling edge. Each access lasts one setup cycle and one access cycle, and the remote vectors return to zero after each pulse. Random traffic includes unmapped offsets and writes with the upper bits set. Directed steps overlap a set with a clear on the same channel, so every collision occurs only in the aligned cycle the properties expect.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int FLAGS  = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_CLR0   = 12'h024;
    localparam logic [11:0] OFS_MASK0  = 12'h028;
    localparam logic [11:0] OFS_STAT0  = 12'h02C;
    localparam logic [11:0] OFS_MSTAT0 = 12'h030;
    localparam logic [11:0] OFS_GEN1   = 12'h040;
    localparam logic [11:0] OFS_MASK1  = 12'h048;
    localparam logic [11:0] OFS_STAT1  = 12'h04C;
    localparam logic [11:0] OFS_MSTAT1 = 12'h050;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_STAT0,
        RD_MASK0,
        RD_MSTAT0,
        RD_STAT1,
        RD_MASK1,
        RD_MSTAT1
    } rd_src_e;

    typedef struct packed {
        logic clr0;
        logic mask0;
        logic gen1;
        logic mask1;
    } wr_sel_t;

    function automatic rd_src_e rd_lookup(input logic [11:0] ofs);
        case (ofs)
            OFS_STAT0:  return RD_STAT0;
            OFS_MASK0:  return RD_MASK0;
            OFS_MSTAT0: return RD_MSTAT0;
            OFS_STAT1:  return RD_STAT1;
            OFS_MASK1:  return RD_MASK1;
            OFS_MSTAT1: return RD_MSTAT1;
            default:    return RD_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/dbell_bus_decode.sv
module dbell_bus_decode
    import dbell_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          psel_i,
    input  logic          penable_i,
    input  logic          pwrite_i,
    input  logic [AW-1:0] paddr_i,
    output wr_sel_t       wr_o,
    output rd_src_e       rd_o
);

    logic wr_fire;
    logic [11:0] ofs;

    assign wr_fire = psel_i && penable_i && pwrite_i;

    // Offsets are 12-bit; wider address buses must be zero above bit 11
    generate
        if (AW > 12) begin : g_wide
            logic hi_zero;
            assign hi_zero = (paddr_i[AW-1:12] == '0);
            assign ofs     = hi_zero ? paddr_i[11:0] : 12'hFFF;
        end else begin : g_narrow
            assign ofs = 12'(paddr_i);
        end
    endgenerate

    always_comb begin
        wr_o       = '0;
        wr_o.clr0  = wr_fire && (ofs == OFS_CLR0);
        wr_o.mask0 = wr_fire && (ofs == OFS_MASK0);
        wr_o.gen1  = wr_fire && (ofs == OFS_GEN1);
        wr_o.mask1 = wr_fire && (ofs == OFS_MASK1);
        rd_o       = (psel_i && !pwrite_i) ? rd_lookup(ofs) : RD_ZERO;
    end

endmodule

// File: rtl/dbell_flag_bank.sv
module dbell_flag_bank #(
    parameter int NF = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic          mask_we_i,
    input  logic [NF-1:0] mask_d_i,
    output logic [NF-1:0] stat_o,
    output logic [NF-1:0] mask_o,
    output logic [NF-1:0] mstat_o,
    output logic          irq_o
);

    logic [NF-1:0] stat_q;
    logic [NF-1:0] mask_q;

    // Clear is applied first, then set, so a colliding set survives
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_i;
            if (mask_we_i) mask_q <= mask_d_i;
        end
    end

    assign stat_o  = stat_q;
    assign mask_o  = mask_q;
    assign mstat_o = stat_q & ~mask_q;
    assign irq_o   = |mstat_o;

endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int NF = FLAGS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psel_i,
    input  logic          penable_i,
    input  logic          pwrite_i,
    input  logic [AW-1:0] paddr_i,
    input  logic [DW-1:0] pwdata_i,
    output logic [DW-1:0] prdata_o,
    input  logic [NF-1:0] rmt_raise_i,
    input  logic [NF-1:0] rmt_ack_i,
    output logic          irq_local_o,
    output logic          irq_remote_o
);

    localparam int NDIR = 2;

    wr_sel_t wr;
    rd_src_e rd;

    logic [NF-1:0] set_v   [NDIR];
    logic [NF-1:0] clr_v   [NDIR];
    logic          mwe_v   [NDIR];
    logic [NF-1:0] stat_v  [NDIR];
    logic [NF-1:0] mask_v  [NDIR];
    logic [NF-1:0] mstat_v [NDIR];
    logic          irq_v   [NDIR];

    logic [NF-1:0] wflags;
    logic          unused_hi;

    assign wflags    = pwdata_i[NF-1:0];
    assign unused_hi = ^pwdata_i[DW-1:NF];

    dbell_bus_decode #(.AW(AW)) u_dec (
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .paddr_i   (paddr_i),
        .wr_o      (wr),
        .rd_o      (rd)
    );

    // Direction 0: remote raises, local clears
    assign set_v[0] = rmt_raise_i;
    assign clr_v[0] = wr.clr0 ? wflags : '0;
    assign mwe_v[0] = wr.mask0;
    // Direction 1: local raises, remote clears
    assign set_v[1] = wr.gen1 ? wflags : '0;
    assign clr_v[1] = rmt_ack_i;
    assign mwe_v[1] = wr.mask1;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            dbell_flag_bank #(.NF(NF)) u_bank (
                .clk       (clk),
                .rst       (rst),
                .set_i     (set_v[d]),
                .clr_i     (clr_v[d]),
                .mask_we_i (mwe_v[d]),
                .mask_d_i  (wflags),
                .stat_o    (stat_v[d]),
                .mask_o    (mask_v[d]),
                .mstat_o   (mstat_v[d]),
                .irq_o     (irq_v[d])
            );
        end
    endgenerate

    logic [NF-1:0] rd_flags;

    always_comb begin
        case (rd)
            RD_STAT0:  rd_flags = stat_v[0];
            RD_MASK0:  rd_flags = mask_v[0];
            RD_MSTAT0: rd_flags = mstat_v[0];
            RD_STAT1:  rd_flags = stat_v[1];
            RD_MASK1:  rd_flags = mask_v[1];
            RD_MSTAT1: rd_flags = mstat_v[1];
            default:   rd_flags = '0;
        endcase
    end

    assign prdata_o     = {{(DW-NF){1'b0}}, rd_flags};
    assign irq_local_o  = irq_v[0];
    assign irq_remote_o = irq_v[1];

    // Flat views for the bound checker
    logic [NF-1:0] stat0_w, stat1_w, mask0_w, mask1_w;
    assign stat0_w = stat_v[0];
    assign stat1_w = stat_v[1];
    assign mask0_w = mask_v[0];
    assign mask1_w = mask_v[1];

endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk
    import dbell_pkg::*;
#(
    parameter int NF = FLAGS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst,
    input logic          psel_i,
    input logic          penable_i,
    input logic          pwrite_i,
    input logic [AW-1:0] paddr_i,
    input logic [DW-1:0] pwdata_i,
    input logic [NF-1:0] rmt_raise_i,
    input logic [NF-1:0] rmt_ack_i,
    input logic          irq_local_o,
    input logic          irq_remote_o,
    input logic [NF-1:0] st0,
    input logic [NF-1:0] st1,
    input logic [NF-1:0] mk0,
    input logic [NF-1:0] mk1
);

    logic          fire;
    logic [NF-1:0] wd;
    assign fire = psel_i && penable_i && pwrite_i;
    assign wd   = pwdata_i[NF-1:0];

    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (st0 == '0 && st1 == '0 && mk0 == '0 && mk1 == '0));

    p_gen_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && paddr_i == AW'(OFS_GEN1)) |=> ((st1 & $past(wd)) == $past(wd)));

    p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && paddr_i == AW'(OFS_CLR0) && rmt_raise_i == '0)
        |=> ((st0 & $past(wd)) == '0));

    p_ack_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (rmt_ack_i != '0 && !(fire && paddr_i == AW'(OFS_GEN1)))
        |=> ((st1 & $past(rmt_ack_i)) == '0));

    // Also covers R7: a raise survives a simultaneous clear
    p_raise_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (rmt_raise_i != '0) |=> ((st0 & $past(rmt_raise_i)) == $past(rmt_raise_i)));

    p_full_mask_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mk0 == '1) |-> !irq_local_o);

    p_full_mask1_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mk1 == '1) |-> !irq_remote_o);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!fire && rmt_raise_i == '0 && rmt_ack_i == '0)
        |=> ($stable(st0) && $stable(st1) && $stable(mk0) && $stable(mk1)));

endmodule

bind dbell_mailbox dbell_mailbox_chk #(.NF(NF), .AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .psel_i       (psel_i),
    .penable_i    (penable_i),
    .pwrite_i     (pwrite_i),
    .paddr_i      (paddr_i),
    .pwdata_i     (pwdata_i),
    .rmt_raise_i  (rmt_raise_i),
    .rmt_ack_i    (rmt_ack_i),
    .irq_local_o  (irq_local_o),
    .irq_remote_o (irq_remote_o),
    .st0          (stat0_w),
    .st1          (stat1_w),
    .mk0          (mask0_w),
    .mk1          (mask1_w)
);

// File: tb/dbell_mailbox_tb.sv
`timescale 1ns/1ps
module dbell_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
    logic [11:0] paddr_i = '0;
    logic [31:0] pwdata_i = '0;
    logic [31:0] prdata_o;
    logic [15:0] rmt_raise_i = '0, rmt_ack_i = '0;
    logic        irq_local_o, irq_remote_o;

    always #2.5 clk = ~clk;

    dbell_mailbox u_dut (
        .clk(clk), .rst(rst),
        .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
        .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
        .rmt_raise_i(rmt_raise_i), .rmt_ack_i(rmt_ack_i),
        .irq_local_o(irq_local_o), .irq_remote_o(irq_remote_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_s0 = '0, m_s1 = '0, m_k0 = '0, m_k1 = '0;

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h02C: return {16'h0, m_s0};
            12'h028: return {16'h0, m_k0};
            12'h030: return {16'h0, m_s0 & ~m_k0};
            12'h04C: return {16'h0, m_s1};
            12'h048: return {16'h0, m_k1};
            12'h050: return {16'h0, m_s1 & ~m_k1};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_check(input logic [11:0] a, input string req);
        @(negedge clk);
        psel_i = 1'b1; pwrite_i = 1'b0; penable_i = 1'b0; paddr_i = a;
        #1;
        check(req, $sformatf("read 0x%h", a), prdata_o, exp_read(a));
        psel_i = 1'b0;
    endtask

    task automatic check_irq(input string req);
        check(req, "irq_local",  {31'h0, irq_local_o},  {31'h0, |(m_s0 & ~m_k0)});
        check(req, "irq_remote", {31'h0, irq_remote_o}, {31'h0, |(m_s1 & ~m_k1)});
    endtask

    task automatic check_all(input string req);
        rd_check(12'h02C, req);
        rd_check(12'h028, req);
        rd_check(12'h030, req);
        rd_check(12'h04C, req);
        rd_check(12'h048, req);
        rd_check(12'h050, req);
        check_irq(req);
    endtask

    // Write with optional remote activity aligned to the access-phase edge
    task automatic xfer(input logic [11:0] a, input logic [31:0] d,
                        input logic [15:0] raise, input logic [15:0] ack);
        @(negedge clk);
        psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d;
        @(negedge clk);
        penable_i = 1'b1; rmt_raise_i = raise; rmt_ack_i = ack;
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
        rmt_raise_i = '0; rmt_ack_i = '0;
        m_s0 = (m_s0 & ~((a == 12'h024) ? d[15:0] : 16'h0)) | raise;
        m_s1 = (m_s1 & ~ack) | ((a == 12'h040) ? d[15:0] : 16'h0);
        if (a == 12'h028) m_k0 = d[15:0];
        if (a == 12'h048) m_k1 = d[15:0];
    endtask

    task automatic remote(input logic [15:0] raise, input logic [15:0] ack);
        @(negedge clk);
        rmt_raise_i = raise; rmt_ack_i = ack;
        @(negedge clk);
        rmt_raise_i = '0; rmt_ack_i = '0;
        m_s0 = m_s0 | raise;
        m_s1 = m_s1 & ~ack;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    localparam logic [11:0] ADDRS [12] = '{12'h000, 12'h024, 12'h028, 12'h02C,
                                          12'h030, 12'h040, 12'h048, 12'h04C,
                                          12'h050, 12'h004, 12'h044, 12'hFFC};

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20241);
        repeat (3) @(negedge clk);
        check_irq("R1 in reset");
        @(negedge clk); rst = 1'b0;
        check_all("R1 after reset");

        // R2 + R8: ones above bit 15 change nothing
        xfer(12'h040, 32'hFFFF_0004, '0, '0);
        check_all("R2/R8 generate with high bits");
        xfer(12'h040, 32'h0000_8001, '0, '0);
        check_all("R2 generate zeros no effect");
        rd_check(12'h040, "R9 generate reads zero");

        // R4, R3, R10
        remote(16'h00F0, '0);
        check_all("R4 remote raise");
        xfer(12'h024, 32'hFFFF_0030, '0, '0);
        check_all("R3 clear-0 and R10 timing");
        remote('0, 16'h0004);
        check_all("R3 remote ack");

        // R5, R6: full mask quiets interrupt while status latches
        xfer(12'h028, 32'hFFFF_FFFF, '0, '0);
        remote(16'h0100, '0);
        check_all("R6 full mask, status latches");
        xfer(12'h028, 32'h0000_00C0, '0, '0);
        check_all("R5 partial mask view");

        // R7: set and clear collide on one edge
        xfer(12'h024, 32'h0000_0008, 16'h0008, '0);
        check_all("R7 raise vs clear-0");
        xfer(12'h040, 32'h0000_0010, '0, 16'h0010);
        check_all("R7 generate vs ack");

        // R9: writes to read-only/unmapped/control change nothing
        xfer(12'h02C, 32'hFFFF_FFFF, '0, '0);
        xfer(12'h000, 32'hFFFF_FFFF, '0, '0);
        xfer(12'h054, 32'hFFFF_FFFF, '0, '0);
        check_all("R9 ignored writes");
        rd_check(12'h000, "R9 control reads zero");
        rd_check(12'h7F0, "R9 unmapped reads zero");
        rd_check(12'h024, "R9 clear reads zero");

        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic [15:0] r, k;
            a = ADDRS[$urandom_range(0, 11)];
            d = $urandom;
            r = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            k = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            if ($urandom_range(0, 4) == 0) remote(r, k);
            else xfer(a, d, r, k);
            check_all("R2/R3/R4/R5/R6/R7 random");
            rd_check(a, "R9/R10 random read");
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_s0 = '0; m_s1 = '0; m_k0 = '0; m_k1 = '0;
        check_all("R1 re-reset");
        finish_run();
    end

endmodule